// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block is the synchronous control logic for the logic side of an isolated power-switch gate driver. It takes a complementary pair of command inputs and drives three output-stage enables: a pull-up, a weak (soft) pull-down and a strong (hard) pull-down. Short noise pulses on the commands are filtered out. The gate turns on only for one polarity combination, and only while the supply is good.

When the desaturation flag rises, the pull-up is cut in the same cycle and the fault output goes low. A soft turn-off window follows. It ends when the gate-low comparator trips or the window runs out, whichever comes first. The block then asserts the hard pull-down and holds it. The fault stays latched until the clear input gives a falling edge while the supply is good and the turn-off sequence has finished. After that, the output stays muted until the commands have returned to the off state.

Undervoltage drops the ready output and forces the gate low. No fault is latched for undervoltage. All pins are plain control and status signals; there is no data stream, so the block has no valid/ready handshake.

Top module: `gate_fault_sup`

## Requirements
- R1: `pu_en` is 1 only when the filtered `cmd_pos` is 1 and the filtered `cmd_neg` is 0. The other three combinations give `pu_en`=0 and `hard_pd_en`=1.
- R2: A level change on a command input that lasts fewer than `GLITCH_CYC` clock cycles (20 ns; 4 cycles at the default 5 ns clock) has no effect on the enables. A change that lasts longer is followed.
- R3: In normal operation, `desat`=1 forces `pu_en`=0 in the same cycle, whatever the commands are. `fault_n` goes to 0 at the next clock edge.
- R4: After a desaturation event, `soft_pd_en` is 1 for exactly `SOFT_CYCLES` cycles (2 µs; 400 cycles at the default clock) if `gate_low` stays 0. Then `hard_pd_en` becomes 1.
- R5: If `gate_low` is 1 during the soft window, `hard_pd_en` is 1 from the next edge and `soft_pd_en` drops.
- R6: Once set, `fault_n`=0 holds with `desat` removed and with the commands toggling. During that time `pu_en` stays 0.
- R7: A falling edge on `clr_n` clears the fault only if `ready`=1 and the hard pull-down phase has been reached. An edge during the soft window or while `ready`=0 is ignored.
- R8: `uvlo`=1 drives `ready` to 0 and `pu_en` to 0 within 3 cycles. `ready` returns to 1 after `uvlo` falls.
- R9: After a clear, `pu_en` stays 0 until the filtered commands have been seen in an off combination. After that, a new on command is followed.
- R10: Holding `clr_n` low does not suppress a new fault. Clearing that fault needs a new falling edge.
- R11: `pu_en` is never 1 in the same cycle as `soft_pd_en` or `hard_pd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmd_pos | input | 1 | Non-inverting gate command |
| cmd_neg | input | 1 | Inverting gate command |
| desat | input | 1 | Desaturation detected flag |
| uvlo | input | 1 | Undervoltage on either supply |
| gate_low | input | 1 | Gate below the low threshold |
| clr_n | input | 1 | Active-low fault clear request |
| pu_en | output | 1 | Pull-up stage enable |
| soft_pd_en | output | 1 | Weak pull-down enable |
| hard_pd_en | output | 1 | Strong pull-down enable |
| fault_n | output | 1 | Latched fault, active low |
| ready | output | 1 | Supply good |

## Verification
All four command combinations are applied, which separates a correct AND-NOT gate from one that ignores either input. Command pulses one cycle below and a few cycles above the filter length confirm that the threshold sits at the right count. Two turn-off runs are made, one with the comparator silent and one with the comparator firing partway through, to tell the timeout from the early exit. Clear pulses are applied during the soft window, under undervoltage, after the hard phase and while held low. These show that only a qualified edge releases the latch.

// File: rtl/gd_pkg.sv
package gd_pkg;
  typedef enum logic [1:0] {
    GD_RUN  = 2'd0,
    GD_SOFT = 2'd1,
    GD_HARD = 2'd2,
    GD_HOLD = 2'd3
  } gd_state_e;

  function automatic int unsigned gd_cycles(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction
endpackage

// File: rtl/gd_deglitch.sv
module gd_deglitch #(
  parameter int unsigned GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = (GLITCH_CYC > 2) ? $clog2(GLITCH_CYC) : 1;

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] != filt_q) begin
        if (cnt_q == CW'(GLITCH_CYC - 1)) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign dout = filt_q;

  assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) != $past(filt_q)));
endmodule

// File: rtl/gd_clr_qual.sv
module gd_clr_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic clr_edge
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b111;
    else        sh_q <= {sh_q[1:0], clr_n};
  end

  assign clr_edge = sh_q[2] & ~sh_q[1];

  assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_edge |=> !clr_edge);
endmodule

// File: rtl/gd_fault_fsm.sv
module gd_fault_fsm
  import gd_pkg::*;
#(
  parameter int unsigned SOFT_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic desat,
  input  logic gate_low,
  input  logic clr_edge,
  input  logic ready,
  output logic pu_en,
  output logic soft_pd_en,
  output logic hard_pd_en,
  output logic fault_n
);
  localparam int unsigned SCW = (SOFT_CYCLES > 2) ? $clog2(SOFT_CYCLES) : 1;

  gd_state_e      state_q, state_d;
  logic [SCW-1:0] tmr_q;
  logic           armed;

  assign armed = (state_q == GD_RUN) || (state_q == GD_HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GD_RUN:  if (desat) state_d = GD_SOFT;
      GD_SOFT: if (gate_low || tmr_q == SCW'(SOFT_CYCLES - 1)) state_d = GD_HARD;
      GD_HARD: if (clr_edge && ready) state_d = GD_HOLD;
      GD_HOLD: begin
        if (desat)        state_d = GD_SOFT;
        else if (!cmd_on) state_d = GD_RUN;
      end
      default: state_d = GD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GD_RUN;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == GD_SOFT) tmr_q <= tmr_q + 1'b1;
      else                    tmr_q <= '0;
    end
  end

  assign pu_en      = (state_q == GD_RUN) && cmd_on && ready && !desat;
  assign soft_pd_en = (state_q == GD_SOFT);
  assign hard_pd_en = !pu_en && !soft_pd_en;
  assign fault_n    = armed;

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_en && (soft_pd_en || hard_pd_en)));
  assert_desat_mutes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desat |-> !pu_en);
  assert_early_hard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_pd_en && gate_low) |=> (hard_pd_en && !soft_pd_en));
  assert_uv_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !pu_en);
  assert_clear_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(clr_edge && ready && hard_pd_en));
  assert_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr_edge) |=> !fault_n);
endmodule

// File: rtl/gate_fault_sup.sv
module gate_fault_sup
  import gd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned GLITCH_NS     = 20,
  parameter int unsigned SOFT_NS       = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_pos,
  input  logic cmd_neg,
  input  logic desat,
  input  logic uvlo,
  input  logic gate_low,
  input  logic clr_n,
  output logic pu_en,
  output logic soft_pd_en,
  output logic hard_pd_en,
  output logic fault_n,
  output logic ready
);
  localparam int unsigned GLITCH_CYC  = gd_cycles(GLITCH_NS, CLK_PERIOD_PS);
  localparam int unsigned SOFT_CYCLES = gd_cycles(SOFT_NS, CLK_PERIOD_PS);
  localparam int unsigned N_CMD       = 2;

  logic [N_CMD-1:0] cmd_raw, cmd_flt;
  logic [1:0]       uv_q;
  logic             clr_edge;

  assign cmd_raw = {cmd_neg, cmd_pos};

  for (genvar i = 0; i < N_CMD; i++) begin : g_flt
    gd_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
      .clk (clk),
      .rst_n(rst_n),
      .din (cmd_raw[i]),
      .dout(cmd_flt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_q <= 2'b00;
    else        uv_q <= {uv_q[0], ~uvlo};
  end
  assign ready = uv_q[1];

  gd_clr_qual u_clr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .clr_edge(clr_edge)
  );

  gd_fault_fsm #(.SOFT_CYCLES(SOFT_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_on    (cmd_flt[0] & ~cmd_flt[1]),
    .desat     (desat),
    .gate_low  (gate_low),
    .clr_edge  (clr_edge),
    .ready     (ready),
    .pu_en     (pu_en),
    .soft_pd_en(soft_pd_en),
    .hard_pd_en(hard_pd_en),
    .fault_n   (fault_n)
  );
endmodule

// File: tb/gate_fault_sup_bench.sv
`timescale 1ns/1ps
module gate_fault_sup_bench;
  localparam int GLITCH = 4;
  localparam int SOFT   = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_pos = 0, cmd_neg = 0, desat = 0, uvlo = 0, gate_low = 0, clr_n = 1;
  logic pu_en, soft_pd_en, hard_pd_en, fault_n, ready;
  int vecs = 0, errs = 0;

  always #2.5 clk = ~clk;

  gate_fault_sup u_gate_fault_sup (.*);

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8 reset ready", ready, 0);
    chk("R11 reset pu", pu_en, 0);
    cyc(4);
    chk("R8 ready after reset", ready, 1);
    chk("R6 fault_n idle", fault_n, 1);
    chk("R1 idle hard pd", hard_pd_en, 1);
  endtask

  task automatic t_truth;
    for (int k = 0; k < 4; k++) begin
      cmd_pos = k[0]; cmd_neg = k[1];
      cyc(12);
      chk($sformatf("R1 pu combo %0d", k), pu_en, (k == 1) ? 1 : 0);
      chk($sformatf("R1 hpd combo %0d", k), hard_pd_en, (k == 1) ? 0 : 1);
    end
    cmd_pos = 0; cmd_neg = 0; cyc(12);
  endtask

  task automatic t_glitch;
    int drops;
    cmd_pos = 1; cyc(12);
    drops = 0;
    cmd_neg = 1; cyc(GLITCH - 1); cmd_neg = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (!pu_en) drops++; end
    chk("R2 short pulse ignored", drops, 0);
    cmd_neg = 1; cyc(GLITCH + 3); cmd_neg = 0;
    drops = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (!pu_en) drops++; end
    chk("R2 long pulse followed", (drops > 0) ? 1 : 0, 1);
    cmd_pos = 0; cmd_pos = 1; cyc(12);
    chk("R2 on restored", pu_en, 1);
  endtask

  task automatic t_softrun;
    int n;
    desat = 1; #1;
    chk("R3 pu muted at once", pu_en, 0);
    chk("R3 fault not yet", fault_n, 1);
    cyc(1);
    chk("R3 fault low", fault_n, 0);
    desat = 0;
    n = 0;
    while (soft_pd_en && n < SOFT + 10) begin n++; cyc(1); end
    chk("R4 soft window length", n, SOFT);
    chk("R4 hard after window", hard_pd_en, 1);
    cmd_pos = 0; cyc(12); cmd_pos = 1; cyc(12);
    chk("R6 fault held", fault_n, 0);
    chk("R6 pu held off", pu_en, 0);
  endtask

  task automatic pulse_clr;
    clr_n = 0; cyc(3); clr_n = 1; cyc(6);
  endtask

  task automatic t_clear;
    uvlo = 1; cyc(4);
    chk("R8 ready low", ready, 0);
    pulse_clr();
    chk("R7 clear under uv ignored", fault_n, 0);
    uvlo = 0; cyc(4);
    chk("R8 ready back", ready, 1);
    pulse_clr();
    chk("R7 clear accepted", fault_n, 1);
    cyc(10);
    chk("R9 muted until off", pu_en, 0);
    cmd_pos = 0; cyc(12); cmd_pos = 1; cyc(12);
    chk("R9 on after off", pu_en, 1);
  endtask

  task automatic t_early;
    desat = 1; cyc(1); desat = 0;
    pulse_clr();
    chk("R7 clear in soft ignored", soft_pd_en, 1);
    cyc(20);
    gate_low = 1; cyc(1); gate_low = 0;
    chk("R5 hard after gate low", hard_pd_en, 1);
    chk("R5 soft dropped", soft_pd_en, 0);
    chk("R7 fault still latched", fault_n, 0);
    pulse_clr();
    chk("R7 clear after hard", fault_n, 1);
    cmd_pos = 0; cyc(12); cmd_pos = 1; cyc(12);
  endtask

  task automatic t_heldclr;
    clr_n = 0; cyc(6);
    desat = 1; cyc(1); desat = 0;
    chk("R10 fault with clr held", fault_n, 0);
    gate_low = 1; cyc(1); gate_low = 0;
    cyc(10);
    chk("R10 held low no clear", fault_n, 0);
    clr_n = 1; cyc(4);
    pulse_clr();
    chk("R10 new edge clears", fault_n, 1);
  endtask

  task automatic t_uvrun;
    cmd_pos = 0; cyc(12); cmd_pos = 1; cyc(12);
    chk("R8 on before uv", pu_en, 1);
    uvlo = 1; cyc(3);
    chk("R8 uv forces low", pu_en, 0);
    chk("R8 no fault on uv", fault_n, 1);
    uvlo = 0; cyc(4);
    chk("R8 on after uv", pu_en, 1);
  endtask

  initial begin
    cyc(3); rst_n = 1;
    t_reset(); t_truth(); t_glitch(); t_softrun(); t_clear();
    t_early(); t_heldclr(); t_uvrun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #200000;
    vecs++; errs++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule